// File: doc/BRIEF.md
# Spare Area Status Byte Framer

This block is a byte-wide streaming stage placed between a page buffer and an error-correction engine. The spare (out-of-band) area of a page is treated as N equal chunks. In expand mode the block reads the linear spare stream and writes a gapped stream: every chunk is followed by a four-byte gap that is filled with zeros. In this gapped form the engine has room to write a status byte for each chunk.

In collapse mode the block reads the gapped stream and writes the linear stream, with every gap taken out. The first byte of each gap is the status of that chunk. It is kept in a per-chunk status register file, which can be read at any time through a select input. The other three gap bytes are read and thrown away.

The chunk size, the chunk count and the mode are sampled when a start pulse arrives. Both stream sides use a valid/ready handshake. A one-cycle done pulse closes each frame.

Top module: `spare_gap_framer`

## Requirements
- R1: After reset the block is idle: `inReady`, `outValid` and `frameDone` are 0, and every status entry reads 0x00.
- R2: In expand mode (`cfgExpand`=1) the output holds exactly N×(S+4) bytes. Chunk k of the input (linear offsets k×S to k×S+S−1) appears at gapped offsets k×(S+4) to k×(S+4)+S−1, in order.
- R3: In expand mode the four gap bytes after each chunk are driven as 0x00.
- R4: In collapse mode (`cfgExpand`=0) the block reads N×(S+4) bytes and writes N×S bytes. Gapped bytes k×(S+4)+j with j<S appear at linear offset k×S+j, and all gap bytes are removed.
- R5: In collapse mode the byte at gapped offset S+k×(S+4) is stored as `status[k]`, read on `statusByte` when `statusSel`=k. The remaining three gap bytes leave every status entry unchanged.
- R6: `frameDone` is high for exactly one cycle. It rises the cycle after the handshake of the last gap byte of chunk N−1.
- R7: With `outReady` low during a chunk-data byte, `inReady` is low, so no byte is lost or duplicated under any pattern of stalls on either side.
- R8: A `start` pulse while a frame is in progress, or with S=0 or N=0, is ignored.
- R9: S, N and the mode are captured at `start`; changing `cfgChunkBytes`, `cfgChunkCount` or `cfgExpand` during a frame has no effect on that frame.
- R10: During an expand gap `inReady` is 0. During a collapse gap `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a frame using the configuration inputs |
| cfgExpand | input | 1 | 1: insert gaps; 0: strip gaps and capture status |
| cfgChunkBytes | input | SIZE_W | Bytes per chunk S (1 or more) |
| cfgChunkCount | input | CNT_W | Number of chunks N (1 to MAX_CHUNKS) |
| inData | input | 8 | Input stream byte |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Block accepts the input byte |
| outData | output | 8 | Output stream byte |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Sink accepts the output byte |
| statusSel | input | IDX_W | Status entry to read |
| statusByte | output | 8 | Stored status of chunk `statusSel` |
| frameDone | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench runs both directions with a one-byte chunk, with a full-count frame, and with stalls on the sink while the source idles. Each case targets a distinct failure:
- A wrong end-of-chunk compare would shift every later chunk by one byte.
- A data path that ignores `outReady` would drop bytes under stalls.
- A design that captured every gap byte would report the last gap byte as the status instead of the first.

A directed case changes the configuration and pulses `start` in the middle of a frame; a design that reloads its setup would change the output length. A reset check and a `start` with a zero count cover the idle behaviour.

// File: rtl/sgf_pkg.sv
package sgf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic active;
    logic expand;
    logic dataPhase;
    logic gapPhase;
    logic capture;
  } ctrl_t;
endpackage

// File: rtl/sgf_ctrl.sv
module sgf_ctrl #(
  parameter int SIZE_W    = 8,
  parameter int CNT_W     = 4,
  parameter int IDX_W     = 3,
  parameter int GAP_BYTES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               cfgExpand,
  input  logic [SIZE_W-1:0]  cfgChunkBytes,
  input  logic [CNT_W-1:0]   cfgChunkCount,
  input  logic               beat,
  output sgf_pkg::ctrl_t     ctrl,
  output logic [IDX_W-1:0]   chunkIdx,
  output logic               frameDone
);
  localparam int GAP_W = (GAP_BYTES > 1) ? $clog2(GAP_BYTES) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_BYTES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_GAP} state_t;

  state_t            state;
  logic [SIZE_W-1:0] byteCnt;
  logic [SIZE_W-1:0] sizeQ;
  logic [IDX_W-1:0]  lastIdxQ;
  logic [GAP_W-1:0]  gapCnt;
  logic              expandQ;
  logic              doneQ;
  logic              startOk;

  assign startOk = start && (state == ST_IDLE) && (cfgChunkBytes != '0) && (cfgChunkCount != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      byteCnt  <= '0;
      sizeQ    <= '0;
      lastIdxQ <= '0;
      gapCnt   <= '0;
      expandQ  <= 1'b0;
      chunkIdx <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: if (startOk) begin
          state    <= ST_DATA;
          sizeQ    <= cfgChunkBytes;
          lastIdxQ <= IDX_W'(cfgChunkCount - 1'b1);
          expandQ  <= cfgExpand;
          byteCnt  <= '0;
          gapCnt   <= '0;
          chunkIdx <= '0;
        end
        ST_DATA: if (beat) begin
          if (byteCnt == sizeQ - 1'b1) begin
            state  <= ST_GAP;
            gapCnt <= '0;
          end else begin
            byteCnt <= byteCnt + 1'b1;
          end
        end
        ST_GAP: if (beat) begin
          if (gapCnt == GAP_LAST) begin
            if (chunkIdx == lastIdxQ) begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end else begin
              state    <= ST_DATA;
              chunkIdx <= chunkIdx + 1'b1;
              byteCnt  <= '0;
            end
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.active    = (state != ST_IDLE);
    ctrl.expand    = expandQ;
    ctrl.dataPhase = (state == ST_DATA);
    ctrl.gapPhase  = (state == ST_GAP);
    ctrl.capture   = (state == ST_GAP) && (gapCnt == '0) && !expandQ;
  end

  assign frameDone = doneQ;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  p_byte_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (byteCnt < sizeQ));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> ($stable(sizeQ) && $stable(lastIdxQ) && $stable(expandQ)));

  p_done_from_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameDone) |-> ($past(state) == ST_GAP));
endmodule

// File: rtl/sgf_datapath.sv
module sgf_datapath #(
  parameter int DATA_W     = 8,
  parameter int MAX_CHUNKS = 8,
  parameter int IDX_W      = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  sgf_pkg::ctrl_t     ctrl,
  input  logic [IDX_W-1:0]   chunkIdx,
  input  logic [DATA_W-1:0]  inData,
  input  logic               inValid,
  output logic               inReady,
  output logic [DATA_W-1:0]  outData,
  output logic               outValid,
  input  logic               outReady,
  input  logic [IDX_W-1:0]   statusSel,
  output logic [DATA_W-1:0]  statusByte,
  output logic               beat
);
  logic [MAX_CHUNKS-1:0][DATA_W-1:0] statusFile;

  always_comb begin
    inReady  = 1'b0;
    outValid = 1'b0;
    outData  = '0;
    beat     = 1'b0;
    if (ctrl.dataPhase) begin
      inReady  = outReady;
      outValid = inValid;
      outData  = inData;
      beat     = inValid && outReady;
    end else if (ctrl.gapPhase) begin
      if (ctrl.expand) begin
        outValid = 1'b1;
        beat     = outReady;
      end else begin
        inReady = 1'b1;
        beat    = inValid;
      end
    end
  end

  for (genvar g = 0; g < MAX_CHUNKS; g++) begin : g_status
    always_ff @(posedge clk) begin
      if (!rstN)
        statusFile[g] <= '0;
      else if (ctrl.capture && inValid && (chunkIdx == IDX_W'(g)))
        statusFile[g] <= inData;
    end
  end

  assign statusByte = statusFile[statusSel];

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.active |-> (!inReady && !outValid));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.dataPhase && !outReady) |-> !inReady);

  p_status_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.capture && inValid) |=> $stable(statusFile));

  p_gap_side_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.gapPhase |-> (ctrl.expand ? !inReady : !outValid));
endmodule

// File: rtl/spare_gap_framer.sv
module spare_gap_framer #(
  parameter int DATA_W     = 8,
  parameter int SIZE_W     = 8,
  parameter int MAX_CHUNKS = 8,
  parameter int GAP_BYTES  = 4,
  localparam int CNT_W     = $clog2(MAX_CHUNKS + 1),
  localparam int IDX_W     = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cfgExpand,
  input  logic [SIZE_W-1:0] cfgChunkBytes,
  input  logic [CNT_W-1:0]  cfgChunkCount,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  input  logic [IDX_W-1:0]  statusSel,
  output logic [DATA_W-1:0] statusByte,
  output logic              frameDone
);
  sgf_pkg::ctrl_t   ctrl;
  logic [IDX_W-1:0] chunkIdx;
  logic             beat;

  sgf_ctrl #(
    .SIZE_W(SIZE_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .GAP_BYTES(GAP_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgExpand(cfgExpand),
    .cfgChunkBytes(cfgChunkBytes), .cfgChunkCount(cfgChunkCount),
    .beat(beat), .ctrl(ctrl), .chunkIdx(chunkIdx), .frameDone(frameDone)
  );

  sgf_datapath #(
    .DATA_W(DATA_W), .MAX_CHUNKS(MAX_CHUNKS), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .chunkIdx(chunkIdx),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .statusSel(statusSel), .statusByte(statusByte), .beat(beat)
  );
endmodule

// File: tb/sim_spare_gap_framer.sv
`timescale 1ns/1ps
module sim_spare_gap_framer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       cfgExpand = 1'b0;
  logic [7:0] cfgChunkBytes = '0;
  logic [3:0] cfgChunkCount = '0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] outData;
  logic       outValid;
  logic       outReady = 1'b0;
  logic [2:0] statusSel = '0;
  logic [7:0] statusByte;
  logic       frameDone;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spare_gap_framer u0 (
    .clk(clk), .rstN(rstN), .start(start), .cfgExpand(cfgExpand),
    .cfgChunkBytes(cfgChunkBytes), .cfgChunkCount(cfgChunkCount),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .statusSel(statusSel), .statusByte(statusByte), .frameDone(frameDone)
  );

  // {expand, chunkBytes, chunkCount, stallMod, seed}
  localparam logic [32:0] VEC [6] = '{
    {1'b1, 8'd4,  8'd2, 8'd0, 8'd3},
    {1'b1, 8'd1,  8'd1, 8'd2, 8'd10},
    {1'b1, 8'd16, 8'd4, 8'd3, 8'd21},
    {1'b0, 8'd4,  8'd2, 8'd0, 8'd5},
    {1'b0, 8'd1,  8'd3, 8'd2, 8'd40},
    {1'b0, 8'd12, 8'd8, 8'd4, 8'd77}
  };

  logic [7:0] src [512];
  logic [7:0] expd [512];
  logic [7:0] got [512];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input bit ex, input int sz, input int cnt);
    @(negedge clk);
    cfgExpand = ex; cfgChunkBytes = 8'(sz); cfgChunkCount = 4'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_frame(input bit ex, input int sz, input int cnt, input int stallMod,
                           input int seed, input bit midChange);
    int inLen, outLen, sent, recv, doneSeen, lastHs, doneIter, badGapSide, zeroBad, mism;
    inLen  = ex ? sz*cnt : cnt*(sz+4);
    outLen = ex ? cnt*(sz+4) : sz*cnt;
    for (int i = 0; i < inLen; i++) src[i] = 8'((i*7 + seed + 1) | 1);
    for (int k = 0; k < cnt; k++) begin
      for (int j = 0; j < sz; j++) begin
        if (ex) expd[k*(sz+4)+j] = src[k*sz+j];
        else    expd[k*sz+j]     = src[k*(sz+4)+j];
      end
      if (ex) for (int j = 0; j < 4; j++) expd[k*(sz+4)+sz+j] = 8'h00;
    end
    pulse_start(ex, sz, cnt);
    sent = 0; recv = 0; doneSeen = 0; lastHs = -1; doneIter = -1;
    badGapSide = 0; zeroBad = 0;
    for (int it = 0; it < 4000; it++) begin
      @(negedge clk);
      if (midChange && it == 2) begin
        cfgChunkBytes = 8'(sz + 3); cfgChunkCount = 4'(cnt + 1); cfgExpand = !ex; start = 1'b1;
      end else start = 1'b0;
      inValid  = (sent < inLen) && !(seed[0] && (it % 3 == 1));
      inData   = (sent < inLen) ? src[sent] : 8'h00;
      outReady = (stallMod == 0) ? 1'b1 : ((it % stallMod) != 0);
      #1;
      if (frameDone) begin doneSeen++; doneIter = it; end
      // R10: gap side quiet
      if (ex && outValid && recv < outLen && (recv % (sz+4)) >= sz && inReady) badGapSide++;
      if (!ex && outValid && sent < inLen && (sent % (sz+4)) >= sz) badGapSide++;
      if (inValid && inReady) begin sent++; lastHs = it; end
      if (outValid && outReady) begin
        if (recv < 512) got[recv] = outData;
        recv++; lastHs = it;
      end
      if (doneSeen > 0 && it > doneIter + 2) break;
    end
    start = 1'b0; inValid = 1'b0; outReady = 1'b0;
    check(sent == inLen, "R7 bytes consumed", sent, inLen);
    check(recv == outLen, ex ? "R2 output length" : "R4 output length", recv, outLen);
    mism = 0;
    for (int i = 0; i < outLen && i < recv; i++) if (got[i] !== expd[i]) mism++;
    check(mism == 0, ex ? "R2 byte order" : "R4 gap removal", mism, 0);
    check(doneSeen == 1, "R6 done count", doneSeen, 1);
    check(doneIter == lastHs + 1, "R6 done timing", doneIter, lastHs + 1);
    check(badGapSide == 0, "R10 gap handshake side", badGapSide, 0);
    if (ex) begin
      for (int k = 0; k < cnt; k++)
        for (int j = 0; j < 4; j++) if (got[k*(sz+4)+sz+j] !== 8'h00) zeroBad++;
      check(zeroBad == 0, "R3 gap bytes zero", zeroBad, 0);
    end else begin
      for (int k = 0; k < cnt; k++) begin
        @(negedge clk); statusSel = 3'(k); #1;
        check(statusByte == src[k*(sz+4)+sz], "R5 status first gap byte",
              statusByte, src[k*(sz+4)+sz]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check(!inReady && !outValid && !frameDone, "R1 idle outputs", {inReady, outValid, frameDone}, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); statusSel = 3'(k); #1;
      check(statusByte == 8'h00, "R1 status cleared", statusByte, 0);
    end
    // R8: zero count start ignored
    pulse_start(1'b1, 4, 0);
    inValid = 1'b1; outReady = 1'b1; #1;
    check(!inReady && !outValid, "R8 zero count start ignored", {inReady, outValid}, 0);
    inValid = 1'b0; outReady = 1'b0;
    // vector table
    for (int v = 0; v < 6; v++)
      run_frame(VEC[v][32], int'(VEC[v][31:24]), int'(VEC[v][23:16]),
                int'(VEC[v][15:8]), int'(VEC[v][7:0]), 1'b0);
    // R9 and R8: config change plus start mid-frame
    run_frame(1'b1, 3, 2, 0, 8, 1'b1);
    run_frame(1'b0, 2, 2, 2, 9, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule